// File: doc/BRIEF.md
# Half-Duplex Bit Clock and Line Direction Controller

This block derives the serial bit clock of a half-duplex baseband modem from a master clock, divided by a ratio picked with two select inputs. It also decides which way a single shared data line points. In receive the line is driven with recovered receive data. The bit clock either free-runs from the divider or, once the receive clock recovery reports lock, follows the recovered clock.

When the host raises the transmit request, the block stops the bit clock and releases the line so the host can drive it. It then waits a fixed guard interval before the first transmit clock edge. Each rising edge of the transmit clock latches one host data bit into the transmit register, and the first of these edges also opens the transmit output path. When the request drops, the path closes at once, to its mid-level idle value, and the line turns back into an output carrying receive data.

The transmit request arrives asynchronously and passes through a synchroniser before the block acts on it. All other inputs, including the recovered receive clock, lock and data, are taken as synchronous to the master clock.

Top module: `hdx_clock_dir_ctrl`

## Requirements
- R1: In receive without lock, the bit clock free-runs with a period of N master cycles, where N is 128, 256, 512 or 1024 for rate select 0, 1, 2 or 3. It is high for the first N/2 cycles of each period, and it starts high out of reset.
- R2: Transmit request high selects transmit and low selects receive. A change on the request takes effect on the third master clock edge after it is applied, after a two-stage synchroniser.
- R3: When the block enters transmit, the bit clock goes low in that cycle and stays low for exactly 2N master cycles. The first rising transmit edge follows this gap, which lies inside the 2 to 3 bit window.
- R4: From the cycle transmit is entered until receive is re-entered, the line output enable is low (line released).
- R5: Each rising bit-clock edge in transmit latches the host data input into the transmit bit output. The first such edge also raises the transmit path enable, in the same cycle as the clock rises.
- R6: Between rising edges the transmit bit holds its value while the host data changes. After the message it keeps the last bit sent, with the path still open, for as long as the request stays high.
- R7: On return to receive, in the same cycle, the path enable drops, the line output enable goes high, and the line output carries the receive data input.
- R8: In receive with lock high, the bit clock output follows the recovered receive clock input.
- R9: If the request drops during the guard gap, the block returns to receive and the transmit path never opens.
- R10: During and after reset the block is in receive: output enable high, path enable low, transmit bit 0, bit clock high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rate_sel_i | input | 2 | Division select: 0→128, 1→256, 2→512, 3→1024 |
| tx_mode_i | input | 1 | Transmit request (1 transmit, 0 receive), asynchronous |
| tx_data_i | input | 1 | Host data read from the shared line |
| rx_clk_i | input | 1 | Recovered receive clock |
| rx_lock_i | input | 1 | Receive clock recovery locked |
| rx_data_i | input | 1 | Recovered receive data |
| data_clk_o | output | 1 | Bit clock to the host |
| pin_oe_o | output | 1 | Output enable for the shared line (1 = drive) |
| pin_out_o | output | 1 | Value driven on the shared line |
| tx_bit_o | output | 1 | Retimed transmit bit |
| tx_path_en_o | output | 1 | Transmit path open (0 = idle mid-level) |

## Verification
The end of the guard gap and the first transmit bit capture happen in one cycle: the clock rises, the path opens and the data is latched together. The bench reaches this at three rate settings and checks all three outputs in that cycle against a timestamp model. A second collision is a request drop landing just as the guard gap runs. The bench drops the request mid-gap and watches the path enable and the line direction to confirm the path never opens and the line is handed back in the cycle the synchronised drop arrives.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

  typedef enum logic [1:0] {
    DIR_RX  = 2'd0,
    DIR_GAP = 2'd1,
    DIR_TX  = 2'd2
  } dir_state_e;

  // master cycles in one bit for a given select code
  function automatic int unsigned bit_period(input int unsigned base, input int unsigned sel);
    return base << sel;
  endfunction

  // guard interval between release of the line and first transmit edge
  function automatic int unsigned gap_cycles(input int unsigned period);
    return 2 * period;
  endfunction

  // divider output level for a phase within one bit
  function automatic logic free_clk_level(input int unsigned phase, input int unsigned period);
    return phase < (period / 2);
  endfunction

endpackage

// File: rtl/hdx_sync.sv
module hdx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain <= '0;
    else         chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hdx_phase_ctr.sv
module hdx_phase_ctr #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             in_gap_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] gap_last_i,
  output logic [CNT_W-1:0] phase_o,
  output logic             wrap_o,
  output logic             gap_done_o
);
  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] bit_last;

  assign bit_last   = period_i - CNT_W'(1);
  assign wrap_o     = !in_gap_i && (phase_q >= bit_last);
  assign gap_done_o = in_gap_i && (phase_q == gap_last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= '0;
    else if (restart_i) phase_q <= '0;
    else if (wrap_o)    phase_q <= '0;
    else                phase_q <= phase_q + CNT_W'(1);
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/hdx_dir_fsm.sv
module hdx_dir_fsm
  import hdx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       gap_done_i,
  input  logic       wrap_i,
  output dir_state_e state_o,
  output logic       restart_o,
  output logic       open_o,
  output logic       capture_o,
  output logic       to_rx_o
);
  dir_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      DIR_RX:  if (req_i) state_d = DIR_GAP;
      DIR_GAP: begin
        if (!req_i)          state_d = DIR_RX;
        else if (gap_done_i) state_d = DIR_TX;
      end
      DIR_TX:  if (!req_i) state_d = DIR_RX;
      default: state_d = DIR_RX;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= DIR_RX;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign restart_o = (state_d != state_q);
  assign open_o    = (state_q == DIR_GAP) && (state_d == DIR_TX);
  assign capture_o = open_o || ((state_q == DIR_TX) && (state_d == DIR_TX) && wrap_i);
  assign to_rx_o   = (state_q != DIR_RX) && (state_d == DIR_RX);
endmodule

// File: rtl/hdx_clock_dir_ctrl.sv
module hdx_clock_dir_ctrl
  import hdx_pkg::*;
#(
  parameter int unsigned BASE_DIV    = 128,
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] rate_sel_i,
  input  logic             tx_mode_i,
  input  logic             tx_data_i,
  input  logic             rx_clk_i,
  input  logic             rx_lock_i,
  input  logic             rx_data_i,
  output logic             data_clk_o,
  output logic             pin_oe_o,
  output logic             pin_out_o,
  output logic             tx_bit_o,
  output logic             tx_path_en_o
);
  localparam int unsigned MAX_PERIOD = BASE_DIV << ((1 << SEL_W) - 1);
  localparam int unsigned CNT_W      = $clog2(MAX_PERIOD) + 2;

  // named internal events, observed by the bound checker
  logic             req_sync;
  dir_state_e       dir_state;
  logic             evt_restart;
  logic             evt_open;
  logic             evt_capture;
  logic             evt_to_rx;
  logic             evt_wrap;
  logic             evt_gap_done;
  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] gap_last;
  logic             in_gap;
  logic             free_clk;

  assign period   = CNT_W'(bit_period(BASE_DIV, 32'(rate_sel_i)));
  assign gap_last = CNT_W'(gap_cycles(32'(period)) - 1);
  assign in_gap   = (dir_state == DIR_GAP);
  assign free_clk = free_clk_level(32'(phase), 32'(period));

  hdx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (tx_mode_i),
    .q_o    (req_sync)
  );

  hdx_dir_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_sync),
    .gap_done_i (evt_gap_done),
    .wrap_i     (evt_wrap),
    .state_o    (dir_state),
    .restart_o  (evt_restart),
    .open_o     (evt_open),
    .capture_o  (evt_capture),
    .to_rx_o    (evt_to_rx)
  );

  hdx_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (evt_restart),
    .in_gap_i   (in_gap),
    .period_i   (period),
    .gap_last_i (gap_last),
    .phase_o    (phase),
    .wrap_o     (evt_wrap),
    .gap_done_o (evt_gap_done)
  );

  // transmit retiming register and path gate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_bit_o     <= 1'b0;
      tx_path_en_o <= 1'b0;
    end else begin
      if (evt_capture) tx_bit_o <= tx_data_i;
      if (evt_open)       tx_path_en_o <= 1'b1;
      else if (evt_to_rx) tx_path_en_o <= 1'b0;
    end
  end

  // clock source and line direction
  always_comb begin
    unique case (dir_state)
      DIR_GAP: data_clk_o = 1'b0;
      DIR_RX:  data_clk_o = rx_lock_i ? rx_clk_i : free_clk;
      default: data_clk_o = free_clk;
    endcase
  end

  assign pin_oe_o  = (dir_state == DIR_RX);
  assign pin_out_o = pin_oe_o & rx_data_i;
endmodule

// File: rtl/hdx_clock_dir_chk.sv
module hdx_clock_dir_chk #(
  parameter int unsigned BASE_DIV = 128,
  parameter int unsigned SEL_W    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEL_W-1:0] rate_sel_i,
  input logic             req_sync,
  input logic             data_clk_o,
  input logic             pin_oe_o,
  input logic             tx_bit_o,
  input logic             tx_path_en_o
);
  logic [15:0] gap_len;
  logic [15:0] gap_expect;

  assign gap_expect = 16'(2 * (BASE_DIV << rate_sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          gap_len <= '0;
    else if (!pin_oe_o && !tx_path_en_o)  gap_len <= gap_len + 16'd1;
    else                                  gap_len <= '0;
  end

  // R2
  req_rise_releases_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(req_sync) && pin_oe_o) |=> !pin_oe_o);

  // R3
  gap_length_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_path_en_o) |-> (gap_len == gap_expect));

  // R4
  release_clock_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_oe_o) |-> (!data_clk_o && !tx_path_en_o));

  // R5
  open_on_first_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_path_en_o) |-> ($rose(data_clk_o) && !pin_oe_o));

  // R6
  bit_moves_only_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_bit_o) |-> ($rose(data_clk_o) && tx_path_en_o));

  // R7
  req_fall_returns_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_sync) |=> (pin_oe_o && !tx_path_en_o));

  // R7
  drive_excludes_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_path_en_o |-> !pin_oe_o);
endmodule

bind hdx_clock_dir_ctrl hdx_clock_dir_chk #(
  .BASE_DIV (BASE_DIV),
  .SEL_W    (SEL_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rate_sel_i   (rate_sel_i),
  .req_sync     (req_sync),
  .data_clk_o   (data_clk_o),
  .pin_oe_o     (pin_oe_o),
  .tx_bit_o     (tx_bit_o),
  .tx_path_en_o (tx_path_en_o)
);

// File: tb/hdx_clock_dir_ctrl_tb_top.sv
`timescale 1ns/1ps
module hdx_clock_dir_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       tx_mode = 1'b0;
  logic       tx_data = 1'b0;
  logic       rx_clk = 1'b0;
  logic       rx_lock = 1'b0;
  logic       rx_data = 1'b0;
  logic       data_clk, oe, pin_out, tx_bit, path_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hdx_clock_dir_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rate_sel_i(sel), .tx_mode_i(tx_mode),
    .tx_data_i(tx_data), .rx_clk_i(rx_clk), .rx_lock_i(rx_lock), .rx_data_i(rx_data),
    .data_clk_o(data_clk), .pin_oe_o(oe), .pin_out_o(pin_out),
    .tx_bit_o(tx_bit), .tx_path_en_o(path_en)
  );

  // ---------------- timestamp reference model ----------------
  int t = 0;       // edge index
  int ep = 0;      // edge where the current phase started
  int mode = 0;    // 0 receive, 1 guard gap, 2 transmit
  bit m_bit = 0, m_path = 0;
  bit pend[$] = '{0, 0};

  function automatic int nbit();
    return 128 * (1 << sel);
  endfunction

  always @(posedge clk) begin
    int n, prev;
    bit req;
    t++;
    n = nbit();
    if (!rst_n) begin
      mode = 0; ep = t; m_bit = 0; m_path = 0; pend = '{0, 0};
    end else begin
      req = pend.pop_front();
      pend.push_back(tx_mode);
      prev = t - 1 - ep;
      if (mode == 0) begin
        if (req) begin mode = 1; ep = t; end
      end else if (mode == 1) begin
        if (!req) begin mode = 0; ep = t; end
        else if (prev == 2 * n - 1) begin mode = 2; ep = t; m_bit = tx_data; m_path = 1; end
      end else begin
        if (!req) begin mode = 0; ep = t; m_path = 0; end
        else if ((prev % n) == n - 1) m_bit = tx_data;
      end
    end
  end

  task automatic report(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int n, ph;
    bit e_clk;
    #1;
    if (rst_n && !done) begin
      n = nbit();
      ph = t - ep;
      if (mode == 1) e_clk = 0;
      else if (mode == 0 && rx_lock) e_clk = rx_clk;
      else e_clk = ((ph % n) < n / 2);
      report(data_clk == e_clk, mode == 1 ? "R3" : (mode == 2 ? "R5" : (rx_lock ? "R8" : "R1")),
             "data_clk", data_clk, e_clk);
      report(oe == (mode == 0), mode == 0 ? "R7" : "R4", "pin_oe", oe, mode == 0);
      report(pin_out == ((mode == 0) && rx_data), "R7", "pin_out", pin_out, (mode == 0) && rx_data);
      report(tx_bit == m_bit, "R6", "tx_bit", tx_bit, m_bit);
      report(path_en == m_path, mode == 1 ? "R9" : "R5", "path_en", path_en, m_path);
    end
  end

  // ---------------- directed helpers ----------------
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_clk(input bit v);
    int k = 0;
    do begin tick(); #1; k++; end while (data_clk != v && k < 5000);
  endtask

  task automatic measure_period(input int n);
    int hi = 1, lo = 1;
    wait_clk(0);
    wait_clk(1);
    forever begin tick(); #1; if (!data_clk || hi > 5000) break; hi++; end
    forever begin tick(); #1; if (data_clk || lo > 5000) break; lo++; end
    report(hi == n / 2, "R1", "high cycles", hi, n / 2);
    report(lo == n / 2, "R1", "low cycles", lo, n / 2);
  endtask

  task automatic do_reset(input logic [1:0] s);
    tick(); rst_n = 1'b0; tx_mode = 1'b0; sel = s;
    repeat (4) tick();
    rst_n = 1'b1;
    #1;
    report(data_clk == 1, "R10", "reset clk", data_clk, 1);
    report(oe == 1, "R10", "reset oe", oe, 1);
    report(path_en == 0, "R10", "reset path", path_en, 0);
    report(tx_bit == 0, "R10", "reset bit", tx_bit, 0);
  endtask

  // enter transmit, check delay and gap, send bits
  task automatic send_msg(input int n, input logic [15:0] pat, input int nbits);
    int cnt = 0, low = 1;
    tick(); tx_mode = 1'b1; tx_data = pat[0];
    do begin tick(); #1; cnt++; end while (oe && cnt < 10);
    report(cnt == 3, "R2", "edges to release", cnt, 3);
    report(data_clk == 0, "R3", "clk low at entry", data_clk, 0);
    forever begin tick(); #1; if (data_clk || low > 5000) break; low++; end
    report(low == 2 * n, "R3", "gap cycles", low, 2 * n);
    report(path_en == 1, "R5", "path opens on first edge", path_en, 1);
    report(tx_bit == pat[0], "R5", "first bit", tx_bit, pat[0]);
    for (int b = 1; b < nbits; b++) begin
      tick(); tx_data = ~pat[b - 1];            // disturb mid-high
      #1;
      report(tx_bit == pat[b - 1], "R6", "hold between edges", tx_bit, pat[b - 1]);
      wait_clk(0);
      tx_data = pat[b];
      wait_clk(1);
      report(tx_bit == pat[b], "R5", "captured bit", tx_bit, pat[b]);
    end
    repeat (3 * n) tick();
    #1;
    report(tx_bit == pat[nbits - 1], "R6", "last bit held", tx_bit, pat[nbits - 1]);
    report(path_en == 1, "R6", "path still open", path_en, 1);
  endtask

  task automatic leave_tx();
    int cnt = 0;
    tick(); tx_mode = 1'b0; rx_data = 1'b1;
    do begin tick(); #1; cnt++; end while (!oe && cnt < 10);
    report(cnt == 3, "R7", "edges to return", cnt, 3);
    report(path_en == 0, "R7", "path closed", path_en, 0);
    report(pin_out == 1, "R7", "rx data on line", pin_out, 1);
  endtask

  initial begin
    int seen;
    do_reset(2'd0);
    for (int i = 0; i < 400; i++) begin tick(); rx_data = i[3] ^ i[0]; end
    measure_period(128);
    tick(); rx_lock = 1'b1;
    for (int i = 0; i < 60; i++) begin
      tick(); rx_clk = ((i / 3) % 2) != 0; #1;
      report(data_clk == rx_clk, "R8", "follows rx clock", data_clk, rx_clk);
    end
    tick(); rx_lock = 1'b0; rx_clk = 1'b0;
    send_msg(128, 16'b1011_0010_1101_0011, 10);
    leave_tx();
    // R9: abort inside the guard gap
    tick(); tx_mode = 1'b1;
    repeat (100) tick();
    tx_mode = 1'b0;
    seen = 0;
    for (int i = 0; i < 300; i++) begin tick(); #1; if (path_en) seen++; end
    report(seen == 0, "R9", "path opened during abort", seen, 0);
    report(oe == 1, "R9", "line returned", oe, 1);
    do_reset(2'd1);
    measure_period(256);
    send_msg(256, 16'b0110_0101_1100_1010, 5);
    leave_tx();
    do_reset(2'd3);
    measure_period(1024);
    send_msg(1024, 16'b0000_0000_0000_0101, 4);
    leave_tx();
    repeat (20) tick();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule